// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller of an in-order-issue, out-of-order-completion pipeline. Decoded instructions arrive one per cycle in program order. Each carries the index of the functional unit that executes it, a destination register and two source registers. The controller keeps one status entry per functional unit and one pending-producer tag per architectural register. From these it answers three questions every cycle. May the instruction at the head issue? Which units may read their operands from the register file now? Which single finished unit may write its result back?

Nothing is renamed and nothing is forwarded. A value reaches a consumer only through the register file, after its producer has been granted write-back. Hazards are resolved by waiting. WAW and busy-unit conflicts hold the head instruction at issue. RAW conflicts hold a unit before operand read. WAR conflicts hold a finished unit before write-back.

The arithmetic units are outside this block. Each one only pulses its done line when execution ends. Unit tags are the unit index plus one, and tag 0 means "no pending producer".

Top module: `scoreboard_ctrl`

## Requirements
- R1: After reset, and after a reset applied while work is in flight, no unit is busy and no register is pending. `rd_grant` and `wb_grant` are zero, and a valid issue to any unit sees `iss_stall` low.
- R2: `iss_stall` is high in a cycle where `iss_valid` is high and the unit selected by `iss_unit` is busy. An accepted issue (valid with stall low) makes that unit busy from the next cycle.
- R3: `iss_stall` is high when `iss_valid` is high and `iss_dst` names a register that a busy unit will still write. With `iss_valid` low, `iss_stall` is low.
- R4: `rd_grant[u]` is high only while unit u is busy, has not yet read its operands, and neither source has a pending producer. The earliest grant is the cycle after issue.
- R5: `rd_grant[u]` lasts exactly one cycle per instruction. While it is high, `rd_src1`/`rd_src2` slice u (bits u*3 upward, 3 bits each) name the two source registers.
- R6: A one-cycle pulse on `fu_done[u]` while unit u is busy marks it finished. It becomes eligible for write-back from the next cycle.
- R7: A finished unit is held from write-back while another unit that has not read its operands has a ready source equal to the finished unit's destination register.
- R8: At most one bit of `wb_grant` is high per cycle. Among eligible units the earliest-issued wins, whatever its index, and `wb_dst` gives its destination register.
- R9: A write-back grant frees the unit and clears its register's pending tag. Units waiting on that tag get `rd_grant` in the next cycle, and the freed unit can accept an issue in the next cycle.
- R10: A source whose producer is granted write-back in the very cycle of issue is recorded as ready, so that consumer is granted operand read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Head instruction present |
| iss_unit | input | 2 | Functional unit (op class) of the head instruction |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_stall | output | 1 | Head instruction must not issue this cycle |
| fu_done | input | 4 | Per-unit execution-finished pulse |
| rd_grant | output | 4 | Per-unit operand read permission |
| rd_src1 | output | 12 | Per-unit first source register number |
| rd_src2 | output | 12 | Per-unit second source register number |
| wb_grant | output | 4 | One-hot write-back permission |
| wb_dst | output | 3 | Destination register of the granted write-back |

## Verification
The bench builds the block with its defaults: four functional units and eight registers. With so few units and registers, a short scripted program reaches every hazard. These include a busy unit and a pending destination at issue, a consumer parked on an unwritten source, and a finished unit held because a parked consumer still needs the old value. Two units finishing together are used to show that issue age, not unit index, picks the write-back. A consumer that issues while its producer is writing back exercises the same-cycle ready path.

// File: rtl/sb_pkg.sv
package sb_pkg;

    parameter int NUM_FU   = 4;
    parameter int NUM_REGS = 8;

    localparam int UNIT_W = (NUM_FU > 1) ? $clog2(NUM_FU) : 1;
    localparam int REG_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int TAG_W  = $clog2(NUM_FU + 1);

    typedef logic [UNIT_W-1:0] unit_t;
    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [NUM_FU-1:0] fu_vec_t;

    localparam tag_t TAG_NONE = '0;

    // One functional unit status entry
    typedef struct packed {
        logic busy;
        logic done;
        reg_t fi;
        reg_t fj;
        reg_t fk;
        tag_t qj;
        tag_t qk;
        logic rj;
        logic rk;
    } unit_entry_t;

    // Issue packet handed to the selected unit entry
    typedef struct packed {
        reg_t dst;
        reg_t src1;
        reg_t src2;
        tag_t qj;
        tag_t qk;
    } issue_pkt_t;

    function automatic tag_t unit_tag(input int idx);
        return tag_t'(idx + 1);
    endfunction

    // True when the entry still needs register r as a ready, unread operand
    function automatic logic needs_old_value(input unit_entry_t e, input reg_t r);
        return (e.rj && (e.fj == r)) || (e.rk && (e.fk == r));
    endfunction

endpackage

// File: rtl/sb_reg_table.sv
module sb_reg_table
    import sb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_en,
    input  reg_t set_reg,
    input  tag_t set_tag,
    input  logic clr_en,
    input  reg_t clr_reg,
    input  reg_t look_a,
    input  reg_t look_b,
    input  reg_t look_c,
    output tag_t tag_a,
    output tag_t tag_b,
    output tag_t tag_c
);

    tag_t pend [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_REGS; r++) pend[r] <= TAG_NONE;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (set_en && (set_reg == reg_t'(r)))
                    pend[r] <= set_tag;
                else if (clr_en && (clr_reg == reg_t'(r)))
                    pend[r] <= TAG_NONE;
            end
        end
    end

    assign tag_a = pend[look_a];
    assign tag_b = pend[look_b];
    assign tag_c = pend[look_c];

endmodule

// File: rtl/sb_unit_entry.sv
module sb_unit_entry
    import sb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue_en,
    input  issue_pkt_t  pkt,
    input  logic        done_in,
    input  logic        wb_en,
    input  logic        bcast_en,
    input  tag_t        bcast_tag,
    output logic        rd_grant,
    output unit_entry_t ent
);

    assign rd_grant = ent.rj && ent.rk;

    always_ff @(posedge clk) begin
        if (rst || wb_en) begin
            ent <= '0;
        end else if (issue_en) begin
            ent.busy <= 1'b1;
            ent.done <= 1'b0;
            ent.fi   <= pkt.dst;
            ent.fj   <= pkt.src1;
            ent.fk   <= pkt.src2;
            ent.qj   <= pkt.qj;
            ent.qk   <= pkt.qk;
            ent.rj   <= (pkt.qj == TAG_NONE);
            ent.rk   <= (pkt.qk == TAG_NONE);
        end else begin
            if (rd_grant) begin
                // operands consumed: both ready flags drop
                ent.rj <= 1'b0;
                ent.rk <= 1'b0;
            end else begin
                if (bcast_en && (ent.qj != TAG_NONE) && (ent.qj == bcast_tag)) begin
                    ent.qj <= TAG_NONE;
                    ent.rj <= 1'b1;
                end
                if (bcast_en && (ent.qk != TAG_NONE) && (ent.qk == bcast_tag)) begin
                    ent.qk <= TAG_NONE;
                    ent.rk <= 1'b1;
                end
            end
            if (done_in && ent.busy)
                ent.done <= 1'b1;
        end
    end

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter
    import sb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     issue_en,
    input  unit_t                    issue_unit,
    input  unit_entry_t [NUM_FU-1:0] ents,
    output fu_vec_t                  grant,
    output logic                     any,
    output tag_t                     grant_tag,
    output reg_t                     grant_reg
);

    // older[a][b] set: unit a holds an instruction issued before unit b's
    logic [NUM_FU-1:0] older [NUM_FU];
    fu_vec_t war_hold;
    fu_vec_t cand;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < NUM_FU; a++) older[a] <= '0;
        end else if (issue_en) begin
            for (int j = 0; j < NUM_FU; j++) begin
                older[issue_unit][j] <= 1'b0;
                if (unit_t'(j) != issue_unit)
                    older[j][issue_unit] <= 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_FU; i++) begin
            war_hold[i] = 1'b0;
            for (int g = 0; g < NUM_FU; g++) begin
                if ((g != i) && needs_old_value(ents[g], ents[i].fi))
                    war_hold[i] = 1'b1;
            end
            cand[i] = ents[i].busy && ents[i].done && !war_hold[i];
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_FU; i++) begin
            grant[i] = cand[i];
            for (int j = 0; j < NUM_FU; j++) begin
                if ((j != i) && cand[j] && older[j][i])
                    grant[i] = 1'b0;
            end
        end
    end

    always_comb begin
        any       = |grant;
        grant_tag = TAG_NONE;
        grant_reg = '0;
        for (int i = 0; i < NUM_FU; i++) begin
            if (grant[i]) begin
                grant_tag = unit_tag(i);
                grant_reg = ents[i].fi;
            end
        end
    end

endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
    import sb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    iss_valid,
    input  logic [UNIT_W-1:0]       iss_unit,
    input  logic [REG_W-1:0]        iss_dst,
    input  logic [REG_W-1:0]        iss_src1,
    input  logic [REG_W-1:0]        iss_src2,
    output logic                    iss_stall,
    input  logic [NUM_FU-1:0]       fu_done,
    output logic [NUM_FU-1:0]       rd_grant,
    output logic [NUM_FU*REG_W-1:0] rd_src1,
    output logic [NUM_FU*REG_W-1:0] rd_src2,
    output logic [NUM_FU-1:0]       wb_grant,
    output logic [REG_W-1:0]        wb_dst
);

    unit_entry_t [NUM_FU-1:0] ents;
    fu_vec_t    unit_busy;
    fu_vec_t    issue_vec;
    logic       iss_fire;
    tag_t       iss_tag;
    tag_t       q_dst;
    tag_t       q_s1;
    tag_t       q_s2;
    logic       wb_any;
    tag_t       wb_tag;
    reg_t       wb_reg;
    issue_pkt_t pkt;

    sb_reg_table tbl_i (
        .clk     (clk),
        .rst     (rst),
        .set_en  (iss_fire),
        .set_reg (iss_dst),
        .set_tag (iss_tag),
        .clr_en  (wb_any),
        .clr_reg (wb_reg),
        .look_a  (iss_dst),
        .look_b  (iss_src1),
        .look_c  (iss_src2),
        .tag_a   (q_dst),
        .tag_b   (q_s1),
        .tag_c   (q_s2)
    );

    assign iss_tag   = tag_t'(iss_unit) + tag_t'(1);
    assign iss_stall = iss_valid && (unit_busy[iss_unit] || (q_dst != TAG_NONE));
    assign iss_fire  = iss_valid && !iss_stall;

    // a producer leaving this very cycle no longer counts as pending
    always_comb begin
        pkt.dst  = iss_dst;
        pkt.src1 = iss_src1;
        pkt.src2 = iss_src2;
        pkt.qj   = (wb_any && (q_s1 == wb_tag)) ? TAG_NONE : q_s1;
        pkt.qk   = (wb_any && (q_s2 == wb_tag)) ? TAG_NONE : q_s2;
    end

    generate
        for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
            assign issue_vec[u] = iss_fire && (iss_unit == unit_t'(u));

            sb_unit_entry ent_i (
                .clk       (clk),
                .rst       (rst),
                .issue_en  (issue_vec[u]),
                .pkt       (pkt),
                .done_in   (fu_done[u]),
                .wb_en     (wb_grant[u]),
                .bcast_en  (wb_any),
                .bcast_tag (wb_tag),
                .rd_grant  (rd_grant[u]),
                .ent       (ents[u])
            );

            assign unit_busy[u]                 = ents[u].busy;
            assign rd_src1[u*REG_W +: REG_W]    = ents[u].fj;
            assign rd_src2[u*REG_W +: REG_W]    = ents[u].fk;
        end
    endgenerate

    sb_wb_arbiter arb_i (
        .clk        (clk),
        .rst        (rst),
        .issue_en   (iss_fire),
        .issue_unit (iss_unit),
        .ents       (ents),
        .grant      (wb_grant),
        .any        (wb_any),
        .grant_tag  (wb_tag),
        .grant_reg  (wb_reg)
    );

    assign wb_dst = wb_reg;

endmodule

// File: rtl/scoreboard_ctrl_chk.sv
module scoreboard_ctrl_chk
    import sb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic [UNIT_W-1:0] iss_unit,
    input logic              iss_stall,
    input logic [NUM_FU-1:0] rd_grant,
    input logic [NUM_FU-1:0] wb_grant,
    input logic [NUM_FU-1:0] unit_busy
);

    a_r8_single_writeback: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_grant));

    a_r2_busy_unit_stalls: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && unit_busy[iss_unit]) |-> iss_stall);

    a_r3_no_stall_when_idle: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> !iss_stall);

    generate
        for (genvar u = 0; u < NUM_FU; u++) begin : g_chk
            a_r2_issue_marks_busy: assert property (@(posedge clk) disable iff (rst)
                (iss_valid && !iss_stall && (iss_unit == unit_t'(u))) |=> unit_busy[u]);

            a_r4_grant_needs_busy: assert property (@(posedge clk) disable iff (rst)
                rd_grant[u] |-> unit_busy[u]);

            a_r5_read_once: assert property (@(posedge clk) disable iff (rst)
                rd_grant[u] |=> !rd_grant[u]);

            a_r9_wb_frees_unit: assert property (@(posedge clk) disable iff (rst)
                wb_grant[u] |=> !unit_busy[u]);
        end
    endgenerate

endmodule

bind scoreboard_ctrl scoreboard_ctrl_chk chk_i (.*);

// File: tb/scoreboard_ctrl_tb_top.sv
`timescale 1ns/1ps
module scoreboard_ctrl_tb_top;
    import sb_pkg::*;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        iss_valid;
    logic [1:0]  iss_unit;
    logic [2:0]  iss_dst, iss_src1, iss_src2;
    logic        iss_stall;
    logic [3:0]  fu_done;
    logic [3:0]  rd_grant;
    logic [11:0] rd_src1, rd_src2;
    logic [3:0]  wb_grant;
    logic [2:0]  wb_dst;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    scoreboard_ctrl dut_i (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_unit(iss_unit),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_stall(iss_stall), .fu_done(fu_done), .rd_grant(rd_grant),
        .rd_src1(rd_src1), .rd_src2(rd_src2), .wb_grant(wb_grant), .wb_dst(wb_dst)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] u;
        logic [2:0] d;
        logic [2:0] s1;
        logic [2:0] s2;
        logic [3:0] done;
        logic       stall;
        logic [3:0] rd;
        logic [3:0] wb;
        logic [2:0] wdst;
    } step_t;

    // one row per cycle: inputs, then outputs expected in that same cycle
    localparam step_t STEPS [15] = '{
        '{1'b1, 2'd0, 3'd1, 3'd2, 3'd3, 4'b0000, 1'b0, 4'b0000, 4'b0000, 3'd0},
        '{1'b1, 2'd1, 3'd4, 3'd1, 3'd5, 4'b0000, 1'b0, 4'b0001, 4'b0000, 3'd0},
        '{1'b1, 2'd0, 3'd6, 3'd0, 3'd0, 4'b0001, 1'b1, 4'b0000, 4'b0000, 3'd0},
        '{1'b1, 2'd2, 3'd4, 3'd0, 3'd0, 4'b0000, 1'b1, 4'b0000, 4'b0001, 3'd1},
        '{1'b1, 2'd2, 3'd2, 3'd6, 3'd7, 4'b0000, 1'b0, 4'b0010, 4'b0000, 3'd0},
        '{1'b1, 2'd3, 3'd7, 3'd2, 3'd5, 4'b0010, 1'b0, 4'b0100, 4'b0000, 3'd0},
        '{1'b1, 2'd0, 3'd5, 3'd0, 3'd0, 4'b0000, 1'b0, 4'b0000, 4'b0010, 3'd4},
        '{1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000, 1'b0, 4'b0001, 4'b0000, 3'd0},
        '{1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0001, 1'b0, 4'b0000, 4'b0000, 3'd0},
        '{1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0100, 1'b0, 4'b0000, 4'b0000, 3'd0},
        '{1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000, 1'b0, 4'b0000, 4'b0100, 3'd2},
        '{1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000, 1'b0, 4'b1000, 4'b0000, 3'd0},
        '{1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000, 1'b0, 4'b0000, 4'b0001, 3'd5},
        '{1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b1000, 1'b0, 4'b0000, 4'b0000, 3'd0},
        '{1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000, 1'b0, 4'b0000, 4'b1000, 3'd7}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at the falling edge, settle, then the caller checks
    task automatic drive(input logic v, input logic [1:0] u, input logic [2:0] d,
                         input logic [2:0] s1, input logic [2:0] s2, input logic [3:0] dn);
        @(negedge clk);
        iss_valid = v; iss_unit = u; iss_dst = d;
        iss_src1 = s1; iss_src2 = s2; fu_done = dn;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; iss_valid = 1'b0; fu_done = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst = 1'b1; iss_valid = 1'b0; iss_unit = '0; iss_dst = '0;
        iss_src1 = '0; iss_src2 = '0; fu_done = '0;
        do_reset();

        // R1: quiet state after reset
        drive(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000);
        chk("R1 rd_grant after reset", rd_grant, 4'b0000);
        chk("R1 wb_grant after reset", wb_grant, 4'b0000);
        chk("R1 R3 stall idle", iss_stall, 1'b0);

        // scripted program walk
        for (int i = 0; i < 15; i++) begin
            drive(STEPS[i].v, STEPS[i].u, STEPS[i].d, STEPS[i].s1, STEPS[i].s2, STEPS[i].done);
            chk($sformatf("R2 R3 stall step %0d", i), iss_stall, STEPS[i].stall);
            chk($sformatf("R4 R5 read grant step %0d", i), rd_grant, STEPS[i].rd);
            chk($sformatf("R6 R7 R8 R9 writeback step %0d", i), wb_grant, STEPS[i].wb);
            if (STEPS[i].wb != 4'b0000)
                chk($sformatf("R8 wb_dst step %0d", i), wb_dst, STEPS[i].wdst);
            if (i == 4) begin
                chk("R5 rd_src1 unit1", rd_src1[5:3], 3'd1);
                chk("R5 rd_src2 unit1", rd_src2[5:3], 3'd5);
            end
        end

        // R8 oldest wins, R10 same-cycle ready, R9 reuse of freed unit
        do_reset();
        drive(1'b1, 2'd1, 3'd1, 3'd0, 3'd0, 4'b0000);
        chk("R1 issue after reset", iss_stall, 1'b0);
        drive(1'b1, 2'd0, 3'd2, 3'd0, 3'd0, 4'b0000);
        chk("R4 read grant unit1", rd_grant, 4'b0010);
        drive(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000);
        chk("R4 read grant unit0", rd_grant, 4'b0001);
        drive(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0011);
        chk("R6 no writeback in pulse cycle", wb_grant, 4'b0000);
        drive(1'b1, 2'd2, 3'd6, 3'd1, 3'd0, 4'b0000);
        chk("R8 older unit1 wins", wb_grant, 4'b0010);
        chk("R8 wb_dst older", wb_dst, 3'd1);
        chk("R10 issue during producer writeback", iss_stall, 1'b0);
        drive(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000);
        chk("R8 younger unit0 next", wb_grant, 4'b0001);
        chk("R8 wb_dst younger", wb_dst, 3'd2);
        chk("R10 consumer reads next cycle", rd_grant, 4'b0100);
        drive(1'b1, 2'd1, 3'd3, 3'd0, 3'd0, 4'b0000);
        chk("R9 freed unit accepts issue", iss_stall, 1'b0);

        // R1: reset with units and registers in flight
        drive(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000);
        do_reset();
        drive(1'b1, 2'd2, 3'd6, 3'd0, 3'd0, 4'b0000);
        chk("R1 busy unit and pending reg cleared", iss_stall, 1'b0);
        chk("R1 no stale read grant", rd_grant, 4'b0000);

        drive(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000);
        summary();
    end

endmodule